// File: doc/BRIEF.md
# Gated Protocol Timeout Counter

This block measures a protocol delay for a message-driven state machine. The state machine requests a delay by raising a count request. The counter may only run while the module's inbound message queue reports that nothing is waiting. When the delay has run out, the block pulses a completion flag back to the state machine, which then runs its own timeout handling.

Arming needs two conditions on the same clock edge: the count request is high and the queue-empty indication is high. On that edge the programmable period is copied into a private register and the running count is cleared. The count then advances once per cycle. Timeout is declared only when the next count value would be strictly larger than the stored period. Equality is not enough, so a period of P gives P+1 counting edges after the arming edge.

If a message arrives, or if the request is withdrawn before expiry, the count is dropped silently. The block then waits idle for a fresh arming condition.

Top module: `gated_timeout`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the block in idle with the count cleared and finished low, and finished stays low until a new count has been armed.
- R2: Counting is armed only at a rising edge where countReq and queueEmpty are both high. With either one low, the block stays idle and finished stays low.
- R3: periodIn is copied at the arming edge. Changes to periodIn while counting do not affect when finished rises.
- R4: With a latched period P, finished is high in the cycle that follows rising edge number P+1 after the arming edge. A sample taken at the falling edge therefore sees it on the (P+2)th falling edge after the inputs were applied. Reaching a count equal to P does not raise finished.
- R5: finished is high for exactly one cycle, and the block then returns to idle. If countReq and queueEmpty are still both high, the next edge re-arms, and the next pulse comes P+2 cycles after the previous one.
- R6: If countReq or queueEmpty is low at a rising edge while the block is counting, the count is cancelled without a pulse on finished. A later re-arm starts again from zero and takes the full P+2 cycles.
- R7: The full 16-bit period range is supported without wrap. A period of 0 gives finished two falling edges after arming inputs, and a period of 65535 gives it 65537 falling edges after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| countReq | input | 1 | Delay request from the protocol state machine |
| queueEmpty | input | 1 | High while the module's message queue holds nothing |
| periodIn | input | 16 | Delay length, latched when counting is armed |
| finished | output | 1 | One-cycle timeout pulse to the state machine |

## Verification
A wrong internal state here can only show up as a finished pulse in the wrong cycle, or as a missing or extra pulse. A count that was not cleared, a period register that follows its input, or a comparison made on equality would each move the pulse by one or more cycles, or leave the pulse out, in the first delay that exercises them. The reference model in the bench predicts finished for every cycle. A deviation is therefore flagged on the same falling edge where it first appears, rather than at the end of a measured latency. Cancellation is checked by measuring a complete fresh delay after the queue or the request has been dropped. A leftover count would shorten that delay.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic arm;    // latch period, zero the count
    logic step;   // advance the count
    logic clear;  // zero the count
  } dpStrobe_t;
endpackage

// File: rtl/tmo_datapath.sv
module tmo_datapath
  import tmo_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  dpStrobe_t           strobe,
  input  logic [PERIOD_W-1:0] periodIn,
  output logic                overPeriod
);
  localparam int NEXT_W = PERIOD_W + 1;

  logic [PERIOD_W-1:0] periodReg;
  logic [PERIOD_W-1:0] cnt;
  logic [NEXT_W-1:0]   nextCnt;

  // One extra bit so a full-range period never wraps
  assign nextCnt    = {1'b0, cnt} + NEXT_W'(1);
  assign overPeriod = nextCnt > {1'b0, periodReg};

  always_ff @(posedge clk) begin
    if (rst) begin
      periodReg <= '0;
      cnt       <= '0;
    end else if (strobe.arm) begin
      periodReg <= periodIn;
      cnt       <= '0;
    end else if (strobe.clear) begin
      cnt <= '0;
    end else if (strobe.step) begin
      cnt <= nextCnt[PERIOD_W-1:0];
    end
  end

  AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    cnt <= periodReg); // R4

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (strobe.clear && !strobe.arm) |=> (cnt == '0)); // R6

  AST_STEP_STAYS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !strobe.arm && !strobe.clear) |-> !overPeriod); // R7
endmodule

// File: rtl/tmo_control.sv
module tmo_control
  import tmo_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      countReq,
  input  logic      queueEmpty,
  input  logic      overPeriod,
  output dpStrobe_t strobe,
  output logic      finished
);
  typedef enum logic {ST_IDLE, ST_RUN} ctlState_t;

  ctlState_t state, nextState;
  logic gateOk;
  logic expire;

  assign gateOk = countReq && queueEmpty;

  always_comb begin
    strobe    = '0;
    nextState = state;
    expire    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (gateOk) begin
          strobe.arm = 1'b1;
          nextState  = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!gateOk) begin
          strobe.clear = 1'b1;
          nextState    = ST_IDLE;
        end else if (overPeriod) begin
          strobe.clear = 1'b1;
          expire       = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          strobe.step = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      finished <= 1'b0;
    end else begin
      state    <= nextState;
      finished <= expire;
    end
  end

  always @(posedge clk) begin
    if (!rst && $past(rst))
      AST_RESET_IDLE: assert (state == ST_IDLE && !finished); // R1
  end

  AST_IDLE_NEEDS_GATE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !gateOk) |=> (state == ST_IDLE && !finished)); // R2

  AST_FINISH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    finished |=> !finished); // R5

  AST_FINISH_RETURNS_IDLE: assert property (@(posedge clk) disable iff (rst)
    finished |-> (state == ST_IDLE)); // R5

  AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !gateOk) |=> (!finished && state == ST_IDLE)); // R6
endmodule

// File: rtl/gated_timeout.sv
module gated_timeout
  import tmo_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                countReq,
  input  logic                queueEmpty,
  input  logic [PERIOD_W-1:0] periodIn,
  output logic                finished
);
  dpStrobe_t strobe;
  logic      overPeriod;

  tmo_control u_ctl (
    .clk        (clk),
    .rst        (rst),
    .countReq   (countReq),
    .queueEmpty (queueEmpty),
    .overPeriod (overPeriod),
    .strobe     (strobe),
    .finished   (finished)
  );

  tmo_datapath #(.PERIOD_W(PERIOD_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .periodIn   (periodIn),
    .overPeriod (overPeriod)
  );
endmodule

// File: tb/gated_timeout_test.sv
`timescale 1ns/1ps
module gated_timeout_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        countReq = 1'b0;
  logic        queueEmpty = 1'b0;
  logic [15:0] periodIn = '0;
  logic        finished;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";
  bit done = 0;

  gated_timeout uut (
    .clk(clk), .rst(rst), .countReq(countReq), .queueEmpty(queueEmpty),
    .periodIn(periodIn), .finished(finished)
  );

  always #4 clk = ~clk;

  // Behavioural reference, updated at each rising edge
  bit     mRun = 0;
  longint mCnt = 0;
  longint mPer = 0;
  bit     mFin = 0;
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mRun = 0; mCnt = 0; mFin = 0;
    end else begin
      mFin = 0;
      if (!mRun) begin
        if (countReq && queueEmpty) begin
          mRun = 1; mPer = periodIn; mCnt = 0;
        end
      end else if (!(countReq && queueEmpty)) begin
        mRun = 0; mCnt = 0;
      end else if (mCnt + 1 > mPer) begin
        mFin = 1; mRun = 0; mCnt = 0;
      end else begin
        mCnt++;
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if (finished !== mFin) begin
        fails++;
        $display("FAIL %s model compare at cycle %0d: finished=%0b expected %0b",
                 curReq, cycles, finished, mFin);
      end
    end
  end

  task automatic check(string req, longint act, longint exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Falling edges until finished is seen, after inputs applied at a falling edge
  task automatic waitFinish(int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (finished) begin k = i; break; end
    end
  endtask

  task automatic quietFor(string req, int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (finished) seen++;
    end
    check(req, seen, 0, "finished pulses while not armed/cancelled");
  endtask

  initial begin
    int k;
    // R1 reset
    repeat (3) @(negedge clk);
    check("R1", finished, 0, "finished during reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", finished, 0, "finished after reset");

    // R2 either condition alone does not arm
    curReq = "R2";
    periodIn = 16'd2; countReq = 1'b1; queueEmpty = 1'b0;
    quietFor("R2", 10);
    countReq = 1'b0; queueEmpty = 1'b1;
    quietFor("R2", 10);

    // R4 strictly-greater expiry, P=3
    curReq = "R4";
    periodIn = 16'd3; countReq = 1'b1;
    waitFinish(50, k);
    check("R4", k, 5, "latency for period 3");
    countReq = 1'b0;
    @(negedge clk);

    // R7 period 0
    curReq = "R7";
    periodIn = 16'd0; countReq = 1'b1;
    waitFinish(50, k);
    check("R7", k, 2, "latency for period 0");
    countReq = 1'b0;
    @(negedge clk);

    // R3 period change after arming has no effect
    curReq = "R3";
    periodIn = 16'd5; countReq = 1'b1;
    @(negedge clk);
    periodIn = 16'd1;
    waitFinish(50, k);
    check("R3", k + 1, 7, "latency with period changed after arm");

    // R5 single pulse then re-arm with gate still high (latched period 5)
    curReq = "R5";
    periodIn = 16'd5;
    @(negedge clk);
    check("R5", finished, 0, "finished in cycle after pulse");
    waitFinish(50, k);
    check("R5", k + 1, 7, "spacing between back-to-back pulses");
    countReq = 1'b0;
    quietFor("R5", 8);

    // R6 cancel via queue becoming non-empty
    curReq = "R6";
    periodIn = 16'd4; countReq = 1'b1;
    repeat (3) @(negedge clk);
    queueEmpty = 1'b0;
    @(negedge clk);
    check("R6", finished, 0, "finished after queue cancel");
    queueEmpty = 1'b1;
    waitFinish(50, k);
    check("R6", k, 6, "full latency after queue cancel");
    // R6 cancel via request drop
    repeat (4) @(negedge clk);
    countReq = 1'b0;
    quietFor("R6", 5);
    countReq = 1'b1;
    waitFinish(50, k);
    check("R6", k, 6, "full latency after request drop");
    countReq = 1'b0;
    @(negedge clk);

    // R1 reset in the middle of a count
    curReq = "R1";
    periodIn = 16'd10; countReq = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b1; countReq = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    quietFor("R1", 20);

    // R7 full-range period
    curReq = "R7";
    periodIn = 16'hFFFF; countReq = 1'b1;
    waitFinish(70000, k);
    check("R7", k, 65537, "latency for period 65535");
    countReq = 1'b0;
    @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // Watchdog
  initial begin
    wait (cycles > 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule